// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer for a charge-redistribution successive-approximation converter. It drives the switch controls of the capacitor array and the comparator's auto-zero switch. It resolves the result one bit at a time, from the most significant bit down, using a single-bit comparator decision. At the end it copies the word into an output register and signals completion with an active-high ready/busy line. The analog array, the comparator and the reference are outside the block.

A single control input, `rc_in`, handles both starting conversions and reading results. In convert mode (`mode_read` = 0) the input rests high, and a low pulse starts a conversion. In read mode (`mode_read` = 1) the input rests low, and a high pulse does two things: its rising edge presents the last result, and its falling edge starts the next conversion. The chip select `cs_n` is active low and gates both starting and reading. The block synchronises `rc_in` into the clock domain and acts on its edges.

The state machine has four states. `ST_TRACK` is idle: the array tracks the input and busy is high. `ST_HOLD` opens every switch for one cycle. `ST_TRIAL` runs one cycle for each bit. `ST_XFER` copies the result to the output register while tracking resumes. The transitions are as follows:
- start: a synchronised falling edge with `cs_n` low moves `ST_TRACK` to `ST_HOLD`.
- release: `ST_HOLD` always moves to `ST_TRIAL`.
- last-bit: `ST_TRIAL` moves to `ST_XFER` once the LSB has been decided.
- done: `ST_XFER` always moves to `ST_TRACK`.

Top module: `sarc_ctrl`

## Requirements
- R1: During and right after reset, the state is `ST_TRACK`. `busy` is 1, `samp_sel` and `azero_close` are 1, `trial_en` is 0 and `dout` is all zeros.
- R2: While idle (`busy` = 1), `samp_sel` = 1 (MSB switch to the input, lower switches to the reference) and `azero_close` = 1. `trial_en` is 0.
- R3: In the first busy-low cycle (hold), `samp_sel`, `azero_close` and `trial_en` are all 0.
- R4: Trial k (k = 1..WIDTH) tests bit p = WIDTH-k. `trial_bits` holds the bits already decided above p, a 1 at p, and 0 below p. If `cmp_in` = 1 in that cycle, bit p is kept as 1; otherwise it becomes 0.
- R5: When `busy` rises, `dout` holds the decided word. With a comparator that returns `trial_bits <= code`, that word equals code.
- R6: `busy` is low in the third clock cycle after a start edge is applied to `rc_in`, and it stays low for exactly WIDTH+2 cycles.
- R7: Edges on `rc_in` while `busy` is low are ignored. The conversion length does not change, and no further conversion follows.
- R8: `dout_oe` is 0 whenever `busy` is 0.
- R9: In the last busy-low cycle, `samp_sel` and `azero_close` are already 1 and `trial_en` is 0.
- R10: In convert mode, `dout_oe` = 1 exactly when `cs_n` = 0, `busy` = 1 and the synchronised `rc_in` is high.
- R11: In read mode, `dout_oe` becomes 1 only after a rising edge of `rc_in` that is seen while `busy` = 1 and `cs_n` = 0. It stays 1 while `rc_in` is high. A rising edge seen during a conversion does not enable the outputs.
- R12: With `cs_n` = 1, a falling edge of `rc_in` starts nothing and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rc_in | input | 1 | Read/convert control (asynchronous) |
| cs_n | input | 1 | Chip select, active low |
| mode_read | input | 1 | 0 = convert mode, 1 = read mode |
| cmp_in | input | 1 | Comparator decision: 1 keeps the bit under test |
| samp_sel | output | 1 | Array in sample position |
| azero_close | output | 1 | Comparator auto-zero switch closed |
| trial_en | output | 1 | A trial is in progress |
| trial_bits | output | WIDTH | Array switch positions during a trial (1 = reference, 0 = ground) |
| busy | output | 1 | High when idle, low during a conversion |
| dout | output | WIDTH | Output data register |
| dout_oe | output | 1 | Enable for the output data pad driver |

## Verification
The assertions assume the following about the inputs:
- `cmp_in` is a settled function of `trial_bits` within the same trial cycle.
- `cs_n` does not change in the cycles around an `rc_in` edge.
- `rc_in` pulses last longer than the synchroniser, so both edges are seen.

The bench drives every input on the falling clock edge. It keeps pulses at least two cycles wide and changes `cs_n` only while `rc_in` is steady. Its comparator is the combinational compare `trial_bits <= code`. Every 8-bit code is converted, and lockout glitches are injected into some of the conversions.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_HOLD  = 2'd1,
        ST_TRIAL = 2'd2,
        ST_XFER  = 2'd3
    } sarc_state_e;
endpackage

// File: rtl/sarc_edge_sync.sv
module sarc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign lvl  = sync_q[STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/sarc_approx.sv
module sarc_approx #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             cmp,
    output logic [WIDTH-1:0] trial_bits,
    output logic [WIDTH-1:0] result,
    output logic             last
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] bits_q;
    logic [WIDTH-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            mask_q <= '0;
        end else if (load) begin
            bits_q <= '0;
            mask_q <= TOP_BIT;
        end else if (step) begin
            if (cmp) begin
                bits_q <= bits_q | mask_q;
            end
            mask_q <= mask_q >> 1;
        end
    end

    assign trial_bits = bits_q | mask_q;
    assign result     = bits_q;
    assign last       = mask_q[0];

    // R4: exactly one bit is under test in every trial cycle
    p_one_bit_under_test_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ($countones(mask_q) == 1));
endmodule

// File: rtl/sarc_ctrl.sv
module sarc_ctrl #(
    parameter int WIDTH       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rc_in,
    input  logic             cs_n,
    input  logic             mode_read,
    input  logic             cmp_in,
    output logic             samp_sel,
    output logic             azero_close,
    output logic             trial_en,
    output logic [WIDTH-1:0] trial_bits,
    output logic             busy,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe
);
    import sarc_pkg::*;

    sarc_state_e      state_q, state_d;
    logic             rc_lvl, rc_rise, rc_fall;
    logic             start;
    logic             sa_last;
    logic [WIDTH-1:0] sa_trial, sa_result;
    logic [WIDTH-1:0] data_q;
    logic             rd_armed_q;

    sarc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rc_in),
        .lvl  (rc_lvl),
        .rise (rc_rise),
        .fall (rc_fall)
    );

    sarc_approx #(.WIDTH(WIDTH)) u_approx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_HOLD),
        .step      (state_q == ST_TRIAL),
        .cmp       (cmp_in),
        .trial_bits(sa_trial),
        .result    (sa_result),
        .last      (sa_last)
    );

    assign start = rc_fall & ~cs_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        busy        = 1'b0;
        samp_sel    = 1'b0;
        azero_close = 1'b0;
        trial_en    = 1'b0;
        trial_bits  = '0;
        unique case (state_q)
            ST_TRACK: begin
                busy        = 1'b1;
                samp_sel    = 1'b1;
                azero_close = 1'b1;
                if (start) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                state_d = ST_TRIAL;
            end
            ST_TRIAL: begin
                trial_en   = 1'b1;
                trial_bits = sa_trial;
                if (sa_last) state_d = ST_XFER;
            end
            ST_XFER: begin
                samp_sel    = 1'b1;
                azero_close = 1'b1;
                state_d     = ST_TRACK;
            end
            default: state_d = ST_TRACK;
        endcase
    end

    // output latch and read-mode arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= '0;
            rd_armed_q <= 1'b0;
        end else begin
            if (state_q == ST_XFER) data_q <= sa_result;
            if (!rc_lvl)                           rd_armed_q <= 1'b0;
            else if (rc_rise && busy && !cs_n)     rd_armed_q <= 1'b1;
        end
    end

    assign dout    = data_q;
    assign dout_oe = ~cs_n & busy & (mode_read ? rd_armed_q : rc_lvl);

    // R8: data pads released during a conversion
    p_hiz_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dout_oe);
    // R3: the cycle after start opens every switch
    p_hold_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!samp_sel && !azero_close && !trial_en));
    // R9: tracking already resumed when busy rises
    p_track_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(samp_sel) && $past(azero_close)));
    // R5: the output word only changes at the transfer
    p_data_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_XFER) |=> $stable(data_q));
    // R7: no start accepted mid conversion
    p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && state_q != ST_XFER) |=> !busy);
endmodule

// File: tb/test_sarc_ctrl.sv
module test_sarc_ctrl;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rc_in;
    logic         cs_n;
    logic         mode_read;
    logic [W-1:0] tgt;
    logic         cmp_in;
    logic         samp_sel, azero_close, trial_en, busy, dout_oe;
    logic [W-1:0] trial_bits, dout;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    assign cmp_in = (trial_bits <= tgt);

    sarc_ctrl #(.WIDTH(W)) i_sarc_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rc_in      (rc_in),
        .cs_n       (cs_n),
        .mode_read  (mode_read),
        .cmp_in     (cmp_in),
        .samp_sel   (samp_sel),
        .azero_close(azero_close),
        .trial_en   (trial_en),
        .trial_bits (trial_bits),
        .busy       (busy),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called on a falling clock edge; drives the start edge (rc low) at once
    task automatic run_conv(input int code, input logic rc_after, input bit glitch);
        int lat;
        int bad4, bad6, bad8, bad9, exp_bits;
        tgt   = code[W-1:0];
        rc_in = 1'b0;
        lat   = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 2) rc_in = rc_after;
        end while (busy && lat < 8);
        chk(lat == 3, "R6 start latency", lat, 3);
        chk(!samp_sel && !azero_close && !trial_en, "R3 hold opens switches",
            {samp_sel, azero_close, trial_en}, 0);
        bad4 = 0; bad6 = 0; bad8 = 0; bad9 = 0;
        if (dout_oe) bad8++;
        for (int k = 1; k <= W + 1; k++) begin
            @(negedge clk);
            if (busy) bad6++;
            if (dout_oe) bad8++;
            if (k <= W) begin
                exp_bits = ((code >> (W - k + 1)) << (W - k + 1)) | (1 << (W - k));
                if (!trial_en || int'(trial_bits) != exp_bits) bad4++;
            end else begin
                if (!samp_sel || !azero_close || trial_en) bad9++;
            end
            if (glitch && k == 2) rc_in = ~rc_after;
            if (glitch && k == 4) rc_in = rc_after;
        end
        @(negedge clk);
        chk(bad4 == 0, "R4 trial pattern", bad4, 0);
        chk(bad6 == 0 && busy, "R6 busy low WIDTH+2 cycles", bad6, 0);
        chk(bad8 == 0, "R8 outputs off while busy", bad8, 0);
        chk(bad9 == 0, "R9 tracking before busy rises", bad9, 0);
        chk(int'(dout) == code, "R5 result word", int'(dout), code);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int stay;
        rst_n = 1'b0; rc_in = 1'b1; cs_n = 1'b0; mode_read = 1'b0; tgt = '0;
        repeat (3) @(negedge clk);
        chk(busy && samp_sel && azero_close && !trial_en && dout == '0,
            "R1 reset state", {busy, samp_sel, azero_close, trial_en}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy && samp_sel && azero_close && !trial_en && dout == '0,
            "R1 state after reset", {busy, samp_sel, azero_close, trial_en}, 4'b1110);
        repeat (3) @(negedge clk);
        chk(samp_sel && azero_close && !trial_en, "R2 idle tracking",
            {samp_sel, azero_close, trial_en}, 3'b110);
        chk(dout_oe, "R10 convert idle with rc high", dout_oe, 1);

        // exhaustive convert-mode sweep, lockout glitches on some codes
        for (int c = 0; c < (1 << W); c++) begin
            bit g;
            g = (c % 37 == 5);
            run_conv(c, 1'b1, g);
            chk(dout_oe, "R10 outputs on after conversion", dout_oe, 1);
            if (g) begin
                stay = 0;
                repeat (8) begin @(negedge clk); if (!busy) stay++; end
                chk(stay == 0, "R7 glitch ignored, no restart", stay, 0);
            end
            @(negedge clk);
        end

        // chip select gating
        cs_n = 1'b1;
        @(negedge clk);
        chk(!dout_oe, "R12 deselected outputs off", dout_oe, 0);
        rc_in = 1'b0;
        stay = 0;
        repeat (6) begin @(negedge clk); if (!busy) stay++; end
        chk(stay == 0, "R12 deselected start ignored", stay, 0);
        rc_in = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        chk(dout_oe && dout == tgt, "R10 reselected shows data", int'(dout), int'(tgt));

        // read mode
        mode_read = 1'b1;
        @(negedge clk);
        run_conv(8'h5A, 1'b0, 1'b0);
        chk(!dout_oe, "R11 read mode idle low keeps outputs off", dout_oe, 0);
        rc_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(dout_oe && dout == 8'h5A, "R11 rising edge presents result", int'(dout), 8'h5A);
        run_conv(8'hA5, 1'b0, 1'b0);
        rc_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(dout_oe && dout == 8'hA5, "R11 second read", int'(dout), 8'hA5);
        run_conv(8'h3C, 1'b1, 1'b0);
        chk(!dout_oe, "R11 rise during busy does not enable", dout_oe, 0);
        cs_n = 1'b1;
        @(negedge clk);
        rc_in = 1'b0;
        stay = 0;
        repeat (6) begin @(negedge clk); if (!busy) stay++; end
        chk(stay == 0, "R12 read mode deselected fall ignored", stay, 0);
        cs_n = 1'b0;
        @(negedge clk);
        rc_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(dout_oe && dout == 8'h3C, "R11 read after reselect", int'(dout), 8'h3C);
        cs_n = 1'b1;
        @(negedge clk);
        chk(!dout_oe, "R12 read mode deselect turns outputs off", dout_oe, 0);
        cs_n = 1'b0;
        @(negedge clk);
        run_conv(8'h77, 1'b0, 1'b1);
        stay = 0;
        repeat (8) begin @(negedge clk); if (!busy) stay++; end
        chk(stay == 0, "R7 read mode pulse during busy ignored", stay, 0);
        chk(!dout_oe, "R11 pulse during busy leaves outputs off", dout_oe, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule